// File: doc/BRIEF.md
# Sector Write-Protection Controller

This block decides whether a program or erase request may go ahead. A serial front-end decodes each command. It announces the command and its target address with a request strobe. Once chip select has risen, it reports whether the command ended cleanly or was cut short. The controller holds a write-enable latch, one protection bit for each address sector, a lock bit that freezes those protection bits, and a busy flag. From these it returns a one-cycle grant or deny pulse for every program or erase that completes. It also presents a status byte and the sector protection vector, so the surrounding logic can shift them out.

The lock bit can be cleared only while the write-protect input is low. A status write can set or clear every sector bit at once, provided the lock is open. The array engine reports the end of a granted operation on a done strobe. That strobe clears busy and the write-enable latch. The engine itself is outside this block.

Top module: `wp_guard`

## Requirements
- R1: After a synchronous reset every sector is protected (`sect_prot` all ones), and `status` reads 00h, so the lock, the write-enable latch and busy are all 0.
- R2: `status` bit 7 is the lock, bit 1 is the write-enable latch and bit 0 is busy. Bits 6..2 read 0. Command codes are: 0 set-enable, 1 clear-enable, 2 program, 3 sector erase, 4 whole erase, 5 protect sector, 6 unprotect sector, 7 status write. A command takes effect at `cmd_fin` after its `cmd_req`. A clean set-enable sets the latch and a clean clear-enable clears it.
- R3: The target sector is the top log2(NUM_SECT) address bits. A clean program or sector erase is granted only when the latch is 1 and the target sector is unprotected. A clean whole erase is granted only when the latch is 1 and no sector is protected. `grant` pulses for one cycle after the finishing edge.
- R4: A program or erase that is refused, or that ends with `cmd_ok` low, pulses `deny` for one cycle, clears the latch and does not set busy.
- R5: A grant sets busy. `op_done` while busy clears both busy and the latch.
- R6: While busy, requests and finishes are ignored, so the latch, lock and protection bits hold.
- R7: Protect-sector and unprotect-sector set or clear the target sector's bit only when the latch is 1 and the lock is 0. Either command clears the latch whenever the latch was 1.
- R8: A status write needs the latch and clears it. With the lock at 0, the lock takes data bit 7. Data bits 5..2 equal to 1111 protect every sector, 0000 unprotect every sector, and any other value leaves the sectors alone.
- R9: While the lock is 1, no sector bit changes. A status write can then only rewrite the lock from data bit 7, and only while `wp_act` is 0.
- R10: Every command other than set-enable leaves the lock and the protection bits unchanged when the latch is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_req | input | 1 | Decoded command strobe, captures op and address |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_addr | input | ADDR_W | Target address |
| cmd_fin | input | 1 | End of the pending command (chip select rose) |
| cmd_ok | input | 1 | 1 on a clean end, 0 on an abort |
| wp_act | input | 1 | Write-protect pin, active high |
| sr_data | input | 8 | Byte carried by a status write |
| op_done | input | 1 | Array engine finished the granted operation |
| grant | output | 1 | One-cycle pulse: program or erase may proceed |
| deny | output | 1 | One-cycle pulse: program or erase refused or aborted |
| status | output | 8 | Status byte {lock, 00000, latch, busy} |
| sect_prot | output | NUM_SECT | Per-sector protection bits |

## Verification
The embedded properties hold on every cycle, whatever the stimulus. Grant and deny never pulse together. A grant always follows a set latch. A deny always leaves the latch and busy at 0. Busy rises only together with a grant. Sector bits stay still while the lock is held or busy is high. Only the directed scenarios can show that the right verdict reaches the right sector address. They also show how the global codes 1111 and 0000 behave against the mixed codes 0Fh and F0h, how the write-protect input gates unlocking, and that the latch is consumed on every path.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

    typedef enum logic [2:0] {
        OP_WREN   = 3'd0,
        OP_WRDI   = 3'd1,
        OP_PROG   = 3'd2,
        OP_ERASE  = 3'd3,
        OP_CHIP   = 3'd4,
        OP_PROT   = 3'd5,
        OP_UNPROT = 3'd6,
        OP_WRSR   = 3'd7
    } op_e;

    typedef struct packed {
        logic grant;
        logic deny;
        logic wel_set;
        logic wel_clr;
        logic busy_set;
        logic sect_set;
        logic sect_clr;
        logic glob_set;
        logic glob_clr;
        logic lock_wr;
        logic lock_val;
    } verdict_t;

    localparam logic [3:0] GLOB_ALL_ON  = 4'b1111;
    localparam logic [3:0] GLOB_ALL_OFF = 4'b0000;

    function automatic logic op_needs_array(op_e op);
        return (op == OP_PROG) || (op == OP_ERASE) || (op == OP_CHIP);
    endfunction

    function automatic logic op_needs_wel(op_e op);
        return (op != OP_WREN) && (op != OP_WRDI);
    endfunction

endpackage

// File: rtl/wp_guard_verdict.sv
module wp_guard_verdict
    import wp_guard_pkg::*;
(
    input  op_e         op,
    input  logic        ok,
    input  logic        wel,
    input  logic        lock,
    input  logic        wp_act,
    input  logic [7:0]  sr_data,
    input  logic        tgt_prot,
    input  logic        any_prot,
    output verdict_t    v
);

    logic [3:0] glob_code;
    assign glob_code = sr_data[5:2];

    always_comb begin
        v = '0;
        if (!ok) begin
            if (op_needs_wel(op))   v.wel_clr = 1'b1;
            if (op_needs_array(op)) v.deny    = 1'b1;
        end else begin
            unique case (op)
                OP_WREN: v.wel_set = 1'b1;
                OP_WRDI: v.wel_clr = 1'b1;
                OP_PROG, OP_ERASE: begin
                    if (wel && !tgt_prot) begin
                        v.grant    = 1'b1;
                        v.busy_set = 1'b1;
                    end else begin
                        v.deny    = 1'b1;
                        v.wel_clr = 1'b1;
                    end
                end
                OP_CHIP: begin
                    if (wel && !any_prot) begin
                        v.grant    = 1'b1;
                        v.busy_set = 1'b1;
                    end else begin
                        v.deny    = 1'b1;
                        v.wel_clr = 1'b1;
                    end
                end
                OP_PROT, OP_UNPROT: begin
                    if (wel) begin
                        v.wel_clr = 1'b1;
                        if (!lock) begin
                            v.sect_set = (op == OP_PROT);
                            v.sect_clr = (op == OP_UNPROT);
                        end
                    end
                end
                OP_WRSR: begin
                    if (wel) begin
                        v.wel_clr = 1'b1;
                        if (!lock) begin
                            v.lock_wr  = 1'b1;
                            v.lock_val = sr_data[7];
                            v.glob_set = (glob_code == GLOB_ALL_ON);
                            v.glob_clr = (glob_code == GLOB_ALL_OFF);
                        end else if (!wp_act) begin
                            v.lock_wr  = 1'b1;
                            v.lock_val = sr_data[7];
                        end
                    end
                end
                default: v = '0;
            endcase
        end
    end

endmodule

// File: rtl/wp_guard_bank.sv
module wp_guard_bank #(
    parameter int NUM_SECT = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [$clog2(NUM_SECT)-1:0] idx,
    input  logic                        set_one,
    input  logic                        clr_one,
    input  logic                        glob_set,
    input  logic                        glob_clr,
    output logic [NUM_SECT-1:0]         prot
);

    generate
        for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
            logic hit;
            assign hit = (idx == s[$clog2(NUM_SECT)-1:0]);
            always_ff @(posedge clk) begin
                if (rst)                       prot[s] <= 1'b1;
                else if (glob_set)             prot[s] <= 1'b1;
                else if (glob_clr)             prot[s] <= 1'b0;
                else if (hit && set_one)       prot[s] <= 1'b1;
                else if (hit && clr_one)       prot[s] <= 1'b0;
            end
        end
    endgenerate

    // R8: at most one kind of protection update per cycle
    a_r8_one_update: assert property (@(posedge clk) disable iff (rst)
        $onehot0({set_one, clr_one, glob_set, glob_clr}));

    // R8: global protect leaves every sector protected
    a_r8_glob_on: assert property (@(posedge clk) disable iff (rst)
        glob_set |=> (&prot));

    // R8: global unprotect leaves every sector open
    a_r8_glob_off: assert property (@(posedge clk) disable iff (rst)
        glob_clr |=> (prot == '0));

endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_guard_pkg::*;
#(
    parameter int NUM_SECT = 4,
    parameter int ADDR_W   = 18
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_req,
    input  logic [2:0]          cmd_op,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic                cmd_fin,
    input  logic                cmd_ok,
    input  logic                wp_act,
    input  logic [7:0]          sr_data,
    input  logic                op_done,
    output logic                grant,
    output logic                deny,
    output logic [7:0]          status,
    output logic [NUM_SECT-1:0] sect_prot
);

    localparam int SECT_W = $clog2(NUM_SECT);

    logic              pend_v;
    op_e               pend_op;
    logic [ADDR_W-1:0] pend_addr;
    logic              wel_q, lock_q, busy_q;
    logic              grant_q, deny_q;
    logic              fire;
    logic [SECT_W-1:0] tgt_idx;
    verdict_t          vd;

    assign fire    = cmd_fin && pend_v && !busy_q;
    assign tgt_idx = pend_addr[ADDR_W-1 -: SECT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v    <= 1'b0;
            pend_op   <= OP_WREN;
            pend_addr <= '0;
        end else begin
            if (cmd_fin) pend_v <= 1'b0;
            if (cmd_req && !busy_q) begin
                pend_v    <= 1'b1;
                pend_op   <= op_e'(cmd_op);
                pend_addr <= cmd_addr;
            end
        end
    end

    wp_guard_verdict u_verdict (
        .op       (pend_op),
        .ok       (cmd_ok),
        .wel      (wel_q),
        .lock     (lock_q),
        .wp_act   (wp_act),
        .sr_data  (sr_data),
        .tgt_prot (sect_prot[tgt_idx]),
        .any_prot (|sect_prot),
        .v        (vd)
    );

    wp_guard_bank #(.NUM_SECT(NUM_SECT)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .idx      (tgt_idx),
        .set_one  (fire && vd.sect_set),
        .clr_one  (fire && vd.sect_clr),
        .glob_set (fire && vd.glob_set),
        .glob_clr (fire && vd.glob_clr),
        .prot     (sect_prot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q   <= 1'b0;
            lock_q  <= 1'b0;
            busy_q  <= 1'b0;
            grant_q <= 1'b0;
            deny_q  <= 1'b0;
        end else begin
            grant_q <= fire && vd.grant;
            deny_q  <= fire && vd.deny;
            if (busy_q && op_done) begin
                busy_q <= 1'b0;
                wel_q  <= 1'b0;
            end else if (fire) begin
                if (vd.busy_set)     busy_q <= 1'b1;
                if (vd.wel_set)      wel_q  <= 1'b1;
                else if (vd.wel_clr) wel_q  <= 1'b0;
                if (vd.lock_wr)      lock_q <= vd.lock_val;
            end
        end
    end

    assign grant  = grant_q;
    assign deny   = deny_q;
    assign status = {lock_q, 5'b00000, wel_q, busy_q};

    // R3: grant and deny are exclusive
    a_r3_excl: assert property (@(posedge clk) disable iff (rst)
        !(grant_q && deny_q));

    // R3: a grant needs the write-enable latch set beforehand
    a_r3_grant_wel: assert property (@(posedge clk) disable iff (rst)
        grant_q |-> $past(wel_q));

    // R4: a deny leaves the latch and busy cleared
    a_r4_deny_clear: assert property (@(posedge clk) disable iff (rst)
        deny_q |-> (!wel_q && !busy_q));

    // R5: busy only rises together with a grant
    a_r5_busy_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> grant_q);

    // R6: sector bits hold while busy
    a_r6_busy_hold: assert property (@(posedge clk) disable iff (rst)
        $past(busy_q) |-> $stable(sect_prot));

    // R9: sector bits frozen while the lock is held
    a_r9_lock_freeze: assert property (@(posedge clk) disable iff (rst)
        $past(lock_q) |-> $stable(sect_prot));

    // R9: lock cannot fall while the write-protect pin is asserted
    a_r9_wp_lock: assert property (@(posedge clk) disable iff (rst)
        ($past(wp_act) && $past(lock_q)) |-> lock_q);

endmodule

// File: tb/wp_guard_tb.sv
module wp_guard_tb;
    import wp_guard_pkg::*;

    localparam int NS = 4;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_req = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_fin = 1'b0;
    logic          cmd_ok = 1'b0;
    logic          wp_act = 1'b0;
    logic [7:0]    sr_data = 8'h00;
    logic          op_done = 1'b0;
    logic          grant, deny;
    logic [7:0]    status;
    logic [NS-1:0] sect_prot;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    wp_guard #(.NUM_SECT(NS), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .cmd_req(cmd_req), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_fin(cmd_fin), .cmd_ok(cmd_ok),
        .wp_act(wp_act), .sr_data(sr_data), .op_done(op_done),
        .grant(grant), .deny(deny), .status(status), .sect_prot(sect_prot)
    );

    typedef struct packed {
        logic          dn;
        logic [2:0]    op;
        logic [AW-1:0] ad;
        logic          ok;
        logic          wp;
        logic [7:0]    dt;
        logic          eg;
        logic          ed;
        logic [7:0]    est;
        logic [NS-1:0] epr;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd2, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 4'hF}, // R10 prog, latch 0
        '{1'b0, 3'd0, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h02, 4'hF}, // R2
        '{1'b0, 3'd3, 18'h00100, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 4'hF}, // R3 R4 protected
        '{1'b0, 3'd0, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h02, 4'hF},
        '{1'b0, 3'd6, 18'h10000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 4'hD}, // R7
        '{1'b0, 3'd0, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h02, 4'hD},
        '{1'b0, 3'd3, 18'h10000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 4'hD}, // R4 abort
        '{1'b0, 3'd0, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h02, 4'hD},
        '{1'b0, 3'd3, 18'h12345, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h03, 4'hD}, // R3 R5
        '{1'b0, 3'd1, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h03, 4'hD}, // R6
        '{1'b1, 3'd0, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 4'hD}, // R5 done
        '{1'b0, 3'd0, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h02, 4'hD},
        '{1'b0, 3'd4, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 4'hD}, // R3 whole erase
        '{1'b0, 3'd0, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h02, 4'hD},
        '{1'b0, 3'd7, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 4'h0}, // R8 global off
        '{1'b0, 3'd0, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h02, 4'h0},
        '{1'b0, 3'd7, 18'h00000, 1'b1, 1'b0, 8'hF0, 1'b0, 1'b0, 8'h80, 4'h0}, // R8 lock only
        '{1'b0, 3'd0, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h82, 4'h0},
        '{1'b0, 3'd5, 18'h30000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h80, 4'h0}, // R9 locked
        '{1'b0, 3'd0, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h82, 4'h0},
        '{1'b0, 3'd7, 18'h00000, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b0, 8'h80, 4'h0}, // R9 wp held
        '{1'b0, 3'd0, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h82, 4'h0},
        '{1'b0, 3'd7, 18'h00000, 1'b1, 1'b0, 8'h0F, 1'b0, 1'b0, 8'h00, 4'h0}, // R9 unlock
        '{1'b0, 3'd0, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h02, 4'h0},
        '{1'b0, 3'd4, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h03, 4'h0}, // R3 whole erase ok
        '{1'b1, 3'd0, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 4'h0}, // R5
        '{1'b0, 3'd0, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h02, 4'h0},
        '{1'b0, 3'd7, 18'h00000, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b0, 8'h00, 4'hF}, // R8 global on
        '{1'b0, 3'd7, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 4'hF}, // R10 wrsr, latch 0
        '{1'b0, 3'd0, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h02, 4'hF},
        '{1'b0, 3'd2, 18'h3FFFF, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 4'hF}, // R4 prog refused
        '{1'b0, 3'd0, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h02, 4'hF},
        '{1'b0, 3'd6, 18'h20000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 4'hB}, // R7
        '{1'b0, 3'd0, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h02, 4'hB},
        '{1'b0, 3'd2, 18'h2FFFF, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h03, 4'hB}, // R3 prog ok
        '{1'b1, 3'd0, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 4'hB}, // R5
        '{1'b0, 3'd0, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h02, 4'hB},
        '{1'b0, 3'd1, 18'h00000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 4'hB}  // R2 clear-enable
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [AW-1:0] ad,
                           input logic ok, input logic wp, input logic [7:0] dt);
        @(negedge clk);
        cmd_req = 1'b1; cmd_op = op; cmd_addr = ad;
        @(negedge clk);
        cmd_req = 1'b0; cmd_fin = 1'b1; cmd_ok = ok; wp_act = wp; sr_data = dt;
        @(negedge clk);
        cmd_fin = 1'b0; wp_act = 1'b0;
    endtask

    task automatic pulse_done;
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 status", {8'h00, status}, 16'h0000);
        check("R1 prot", {12'h000, sect_prot}, 16'h000F);
        check("R1 pulses", {14'h0, grant, deny}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].dn) pulse_done;
            else run_cmd(VEC[i].op, VEC[i].ad, VEC[i].ok, VEC[i].wp, VEC[i].dt);
            check($sformatf("R2-R10 vec%0d grant/deny", i), {14'h0, grant, deny},
                  {14'h0, VEC[i].eg, VEC[i].ed});
            check($sformatf("R2-R10 vec%0d status", i), {8'h00, status}, {8'h00, VEC[i].est});
            check($sformatf("R2-R10 vec%0d prot", i), {12'h000, sect_prot}, {12'h000, VEC[i].epr});
        end

        // R3: grant is a single-cycle pulse
        run_cmd(3'd0, '0, 1'b1, 1'b0, 8'h00);
        run_cmd(3'd2, 18'h20000, 1'b1, 1'b0, 8'h00);
        check("R3 grant pulse", {15'h0, grant}, 16'h0001);
        @(negedge clk);
        check("R3 grant drop", {15'h0, grant}, 16'h0000);
        pulse_done;
        check("R5 done clears", {8'h00, status}, 16'h0000);

        // R6: finish strobe without a pending request does nothing
        run_cmd(3'd0, '0, 1'b1, 1'b0, 8'h00);
        @(negedge clk); cmd_fin = 1'b1; cmd_ok = 1'b1;
        @(negedge clk); cmd_fin = 1'b0;
        check("R6 stray finish", {8'h00, status}, 16'h0002);

        // R1: reset mid-state restores defaults
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset status", {8'h00, status}, 16'h0000);
        check("R1 reset prot", {12'h000, sect_prot}, 16'h000F);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule